// File: doc/BRIEF.md
# Table-Driven Bilinear Image Remapper

This block produces a geometrically corrected grayscale image window in one pass. Every pixel of the rectified output has an entry in a precomputed coordinate table. The entry gives a fixed-point position in the captured frame, so lens undistortion and perspective rectification are applied together. For each output pixel the block reads the table entry and fetches the four source pixels around that position. It then blends them with bilinear weights, or, when a mode bit is set, outputs the single nearest one.

Software or a tracking loop requests a rectangular window of the rectified image, normally the neighbourhood of an object's last known position, and pulses start. The block walks the window in raster order. It drives a synchronous read port into the source frame memory and another into the table memory, and streams out one gray value per output pixel. The source frame is 1600 by 1200 pixels of 8 bits.

Top module: `lut_remap`

## Requirements
- R1: After reset, busy, pix_valid, done, lut_rd and src_rd are all low.
- R2: A table entry is 30 bits: integer column in [29:19], integer row in [18:8], column fraction fx in [7:4], row fraction fy in [3:0] (sixteenths). For the window pixel at row r and column c, the table is read at address (win_y+r)*1600 + (win_x+c), with lut_data valid one cycle after lut_rd.
- R3: Per output pixel, four source reads are issued on consecutive cycles in the order (x,y), (x+1,y), (x,y+1), (x+1,y+1). Each address is row*1600 + column, and src_data is valid one cycle after src_rd.
- R4: In blend mode (nn_sel=0 at start) the output is ((16-fx)(16-fy)P00 + fx(16-fy)P10 + (16-fx)fy·P01 + fx·fy·P11 + 128) >> 8.
- R5: When the integer column is 1599 the right neighbour is the same column. When the integer row is 1199 the lower neighbour is the same row.
- R6: In nearest mode (nn_sel=1 at start) the output is the source pixel at column x+1 if fx ≥ 8, else x, and at row y+1 if fy ≥ 8, else y, with the clamping of R5.
- R7: pix_valid is high for exactly one cycle, one cycle after the cycle in which the fourth read's data is returned. The first pixel appears 8 clock edges after the start edge, and each further pixel follows 8 cycles later.
- R8: Exactly win_w*win_h pixels leave, in raster order. done is high for one cycle, in the cycle after the last pixel.
- R9: A window with zero width or zero height produces no pixel, and done is high in the cycle after the start edge.
- R10: start is ignored while busy. The window and mode captured at the accepted start apply to the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a window run (accepted when idle) |
| nn_sel | input | 1 | 1 = nearest pixel, 0 = bilinear blend |
| win_x | input | 11 | Window left column in the rectified image |
| win_y | input | 11 | Window top row in the rectified image |
| win_w | input | 11 | Window width in pixels |
| win_h | input | 11 | Window height in pixels |
| lut_rd | output | 1 | Coordinate table read strobe |
| lut_addr | output | 21 | Coordinate table address |
| lut_data | input | 30 | Table entry, one cycle after lut_rd |
| src_rd | output | 1 | Source frame read strobe |
| src_addr | output | 21 | Source frame address |
| src_data | input | 8 | Source pixel, one cycle after src_rd |
| pix_valid | output | 1 | Output pixel strobe |
| pix_data | output | 8 | Output gray level |
| done | output | 1 | One-cycle end-of-window pulse |
| busy | output | 1 | A run is in progress |

## Verification
The hardest condition to reach from the ports is the clamped fetch at the frame's last column and last row. Ordinary windows never map there. The bench therefore swaps in a table pattern that sends every entry to column 1599. It sends entries alternately to row 1199 and to an interior row, with fractions chosen so that the nearest mode must pick the clamped neighbour. A second start pulse is driven in the middle of a run, and the bench checks that the first window finishes unchanged and that no second run follows.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int PIX_W  = 8;
  localparam int FRAC_W = 4;
  localparam int CRD_W  = 11;
  localparam int ENT_W  = 2*CRD_W + 2*FRAC_W;
  localparam int ONE    = 1 << FRAC_W;
  localparam int ACC_W  = PIX_W + 2*FRAC_W + 2;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [FRAC_W-1:0] frac_t;

  typedef struct packed {
    logic [CRD_W-1:0] x;
    logic [CRD_W-1:0] y;
    frac_t            fx;
    frac_t            fy;
  } ent_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LUT, ST_LWAIT, ST_FETCH, ST_DRAIN, ST_OUT, ST_DONE
  } st_e;

  function automatic pix_t blend4(pix_t p00, pix_t p10, pix_t p01, pix_t p11,
                                  frac_t fx, frac_t fy);
    logic [ACC_W-1:0] bx, by, ax, ay, acc;
    logic [ACC_W-1:0] rnd;
    bx  = ACC_W'(fx);
    by  = ACC_W'(fy);
    ax  = ACC_W'(ONE) - bx;
    ay  = ACC_W'(ONE) - by;
    rnd = ACC_W'(1) << (2*FRAC_W - 1);
    acc = ax*ay*ACC_W'(p00) + bx*ay*ACC_W'(p10)
        + ax*by*ACC_W'(p01) + bx*by*ACC_W'(p11) + rnd;
    return pix_t'(acc >> (2*FRAC_W));
  endfunction

  function automatic pix_t pick_near(pix_t p00, pix_t p10, pix_t p01, pix_t p11,
                                     frac_t fx, frac_t fy);
    case ({fy[FRAC_W-1], fx[FRAC_W-1]})
      2'b00:   return p00;
      2'b01:   return p10;
      2'b10:   return p01;
      default: return p11;
    endcase
  endfunction
endpackage

// File: rtl/remap_walk.sv
module remap_walk import remap_pkg::*; #(
  parameter int DST_W = 1600,
  parameter int TAW   = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CRD_W-1:0] wx,
  input  logic [CRD_W-1:0] wy,
  input  logic [CRD_W-1:0] ww,
  input  logic [CRD_W-1:0] wh,
  output logic [TAW-1:0]   tbl_addr,
  output logic             last,
  output logic             empty
);
  logic [CRD_W-1:0] ox, oy, w_q, h_q, cx, cy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ox <= '0; oy <= '0; w_q <= '0; h_q <= '0; cx <= '0; cy <= '0;
    end else if (load) begin
      ox <= wx; oy <= wy; w_q <= ww; h_q <= wh; cx <= '0; cy <= '0;
    end else if (step) begin
      if (cx == w_q - 1'b1) begin
        cx <= '0;
        cy <= cy + 1'b1;
      end else begin
        cx <= cx + 1'b1;
      end
    end
  end

  assign tbl_addr = (TAW'(oy) + TAW'(cy)) * TAW'(DST_W) + TAW'(ox) + TAW'(cx);
  assign last     = (cx == w_q - 1'b1) && (cy == h_q - 1'b1);
  assign empty    = (ww == '0) || (wh == '0);

  // R8: the raster walk never advances past the last window row
  p_row_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cy < h_q));
endmodule

// File: rtl/remap_gather.sv
module remap_gather import remap_pkg::*; #(
  parameter int SRC_W = 1600,
  parameter int SRC_H = 1200,
  parameter int SAW   = 21
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ent_ld,
  input  ent_t           ent_in,
  input  logic           issue,
  input  logic [1:0]     slot,
  input  logic           cap_en,
  input  logic [1:0]     cap_slot,
  input  pix_t           src_data,
  output logic [SAW-1:0] src_addr,
  output ent_t           ent_q,
  output pix_t [3:0]     smp
);
  localparam logic [CRD_W-1:0] X_LAST = CRD_W'(SRC_W - 1);
  localparam logic [CRD_W-1:0] Y_LAST = CRD_W'(SRC_H - 1);

  logic [CRD_W-1:0] x_nb, y_nb, x_sel, y_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q <= '0;
      smp   <= '0;
    end else begin
      if (ent_ld) ent_q <= ent_in;
      if (cap_en) smp[cap_slot] <= src_data;
    end
  end

  // neighbour coordinates, held at the frame edge
  assign x_nb  = (ent_q.x >= X_LAST) ? ent_q.x : ent_q.x + 1'b1;
  assign y_nb  = (ent_q.y >= Y_LAST) ? ent_q.y : ent_q.y + 1'b1;
  assign x_sel = slot[0] ? x_nb : ent_q.x;
  assign y_sel = slot[1] ? y_nb : ent_q.y;
  assign src_addr = SAW'(y_sel) * SAW'(SRC_W) + SAW'(x_sel);

  // R5: in-frame entries never produce an address outside the frame
  p_addr_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && ent_q.x <= X_LAST && ent_q.y <= Y_LAST) |-> (src_addr < SAW'(SRC_W*SRC_H)));
endmodule

// File: rtl/lut_remap.sv
module lut_remap import remap_pkg::*; #(
  parameter int SRC_W = 1600,
  parameter int SRC_H = 1200,
  parameter int DST_W = 1600,
  parameter int DST_H = 1200,
  localparam int SAW  = $clog2(SRC_W*SRC_H),
  localparam int TAW  = $clog2(DST_W*DST_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             nn_sel,
  input  logic [CRD_W-1:0] win_x,
  input  logic [CRD_W-1:0] win_y,
  input  logic [CRD_W-1:0] win_w,
  input  logic [CRD_W-1:0] win_h,
  output logic             lut_rd,
  output logic [TAW-1:0]   lut_addr,
  input  logic [ENT_W-1:0] lut_data,
  output logic             src_rd,
  output logic [SAW-1:0]   src_addr,
  input  logic [PIX_W-1:0] src_data,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_data,
  output logic             done,
  output logic             busy
);
  st_e        state;
  logic [1:0] slot, cap_slot;
  logic       rd_pend, nn_q;
  logic       last_px, empty_win;
  ent_t       ent_q;
  pix_t [3:0] smp;

  // named internal events
  logic accept_w, last_issue_w, step_w;
  assign accept_w     = (state == ST_IDLE) && start;
  assign last_issue_w = (state == ST_FETCH) && (slot == 2'd3);
  assign step_w       = (state == ST_OUT) && !last_px;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      slot     <= '0;
      cap_slot <= '0;
      rd_pend  <= 1'b0;
      nn_q     <= 1'b0;
    end else begin
      rd_pend  <= (state == ST_FETCH);
      cap_slot <= slot;
      case (state)
        ST_IDLE:  if (start) begin
                    nn_q  <= nn_sel;
                    state <= empty_win ? ST_DONE : ST_LUT;
                  end
        ST_LUT:   state <= ST_LWAIT;
        ST_LWAIT: begin
                    slot  <= '0;
                    state <= ST_FETCH;
                  end
        ST_FETCH: begin
                    slot <= slot + 1'b1;
                    if (slot == 2'd3) state <= ST_DRAIN;
                  end
        ST_DRAIN: state <= ST_OUT;
        ST_OUT:   state <= last_px ? ST_DONE : ST_LUT;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  remap_walk #(.DST_W(DST_W), .TAW(TAW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(accept_w), .step(step_w),
    .wx(win_x), .wy(win_y), .ww(win_w), .wh(win_h),
    .tbl_addr(lut_addr), .last(last_px), .empty(empty_win)
  );

  remap_gather #(.SRC_W(SRC_W), .SRC_H(SRC_H), .SAW(SAW)) u_gather (
    .clk(clk), .rst_n(rst_n), .ent_ld(state == ST_LWAIT), .ent_in(ent_t'(lut_data)),
    .issue(src_rd), .slot(slot), .cap_en(rd_pend), .cap_slot(cap_slot),
    .src_data(src_data), .src_addr(src_addr), .ent_q(ent_q), .smp(smp)
  );

  assign lut_rd    = (state == ST_LUT);
  assign src_rd    = (state == ST_FETCH);
  assign pix_valid = (state == ST_OUT);
  assign done      = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);
  assign pix_data  = nn_q ? pick_near(smp[0], smp[1], smp[2], smp[3], ent_q.fx, ent_q.fy)
                          : blend4(smp[0], smp[1], smp[2], smp[3], ent_q.fx, ent_q.fy);

  // R1: an idle block drives no strobes
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pix_valid && !src_rd && !lut_rd));
  // R7: a pixel follows the fourth read by two cycles
  p_valid_after_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(last_issue_w, 2));
  // R7: valid lasts a single cycle
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);
  // R8: done is a one-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8, R9: done follows either the final pixel or an empty-window start
  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(pix_valid) || $past(accept_w)));
  // R10: a start seen while busy does not restart the walk
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);
endmodule

// File: tb/lut_remap_bench.sv
module lut_remap_bench;
  localparam int CLK_P = 10;
  localparam int SW = 1600;
  localparam int SH = 1200;
  localparam int DW = 1600;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, nn_sel = 1'b0;
  logic [10:0] win_x = '0, win_y = '0, win_w = '0, win_h = '0;
  logic        lut_rd, src_rd, pix_valid, done, busy;
  logic [20:0] lut_addr, src_addr;
  logic [29:0] lut_q = '0;
  logic [7:0]  src_q = '0, pix_data;

  int tests = 0, fails = 0, cyc = 0, map_kind = 0;
  int np = 0, nl = 0, ns = 0, ndone = 0, done_cyc = 0;
  int pv[512], pc[512], la[512], sa[512];

  lut_remap u_lut_remap (
    .clk(clk), .rst_n(rst_n), .start(start), .nn_sel(nn_sel),
    .win_x(win_x), .win_y(win_y), .win_w(win_w), .win_h(win_h),
    .lut_rd(lut_rd), .lut_addr(lut_addr), .lut_data(lut_q),
    .src_rd(src_rd), .src_addr(src_addr), .src_data(src_q),
    .pix_valid(pix_valid), .pix_data(pix_data), .done(done), .busy(busy)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pix_fn(int a);
    return (a*37 + (a >> 7)*11) & 255;
  endfunction

  function automatic logic [29:0] ent_fn(int a);
    int dx, dy, x, y, fx, fy;
    dx = a % DW; dy = a / DW;
    if (map_kind == 0) begin
      x = dx*2 + 1; y = dy + 4; fx = (dx*5 + dy*3) % 16; fy = (dx*7 + dy*11) % 16;
    end else if (dx % 2 == 0) begin
      x = SW - 1; y = SH - 1; fx = 10; fy = 9;
    end else begin
      x = SW - 1; y = 7; fx = 12; fy = 5;
    end
    return {x[10:0], y[10:0], fx[3:0], fy[3:0]};
  endfunction

  // memory models, one cycle read latency
  always @(posedge clk) begin
    if (lut_rd) lut_q <= ent_fn(int'(lut_addr));
    if (src_rd) src_q <= 8'(pix_fn(int'(src_addr)));
  end

  // collector, sampled away from the active edge
  always @(negedge clk) begin
    if (pix_valid && np < 512) begin pv[np] = int'(pix_data); pc[np] = cyc; np++; end
    if (lut_rd && nl < 512) begin la[nl] = int'(lut_addr); nl++; end
    if (src_rd && ns < 512) begin sa[ns] = int'(src_addr); ns++; end
    if (done) begin ndone++; done_cyc = cyc; end
  end

  function automatic int exp_pix(int a, bit nn);
    logic [29:0] e;
    int x0, y0, x1, y1, fx, fy, t, b;
    e = ent_fn(a);
    x0 = int'(e[29:19]); y0 = int'(e[18:8]); fx = int'(e[7:4]); fy = int'(e[3:0]);
    x1 = (x0 == SW-1) ? x0 : x0 + 1;
    y1 = (y0 == SH-1) ? y0 : y0 + 1;
    if (nn) return pix_fn(((fy >= 8) ? y1 : y0)*SW + ((fx >= 8) ? x1 : x0));
    t = pix_fn(y0*SW + x0)*(16 - fx) + pix_fn(y0*SW + x1)*fx;
    b = pix_fn(y1*SW + x0)*(16 - fx) + pix_fn(y1*SW + x1)*fx;
    return (t*(16 - fy) + b*fy + 128) / 256;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic launch(int wx, int wy, int w, int h, bit nn, output int scyc);
    @(negedge clk);
    win_x = 11'(wx); win_y = 11'(wy); win_w = 11'(w); win_h = 11'(h); nn_sel = nn;
    start = 1'b1; scyc = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(int d0);
    for (int i = 0; i < 3000 && ndone == d0; i++) @(negedge clk);
    check(ndone == d0 + 1, "R8 done seen", ndone - d0, 1);
  endtask

  task automatic verify(int wx, int wy, int w, int h, bit nn, int bp, int bl, int scyc, string req);
    int n;
    n = w*h;
    check(np - bp == n, "R8 pixel count", np - bp, n);
    for (int k = 0; k < n && bp + k < np; k++) begin
      int a;
      a = (wy + k / w)*DW + wx + k % w;
      check(la[bl + k] == a, "R2 table address", la[bl + k], a);
      check(pv[bp + k] == exp_pix(a, nn), req, pv[bp + k], exp_pix(a, nn));
      check(pc[bp + k] == scyc + 8 + 8*k, "R7 pixel cycle", pc[bp + k], scyc + 8 + 8*k);
    end
    check(done_cyc == scyc + 8*n + 1, "R8 done cycle", done_cyc, scyc + 8*n + 1);
  endtask

  task automatic t_reset();
    check(!busy && !pix_valid && !done && !lut_rd && !src_rd, "R1 reset state",
          int'({busy, pix_valid, done, lut_rd, src_rd}), 0);
  endtask

  task automatic t_blend_basic();
    int s, bp, bl, bs, d0;
    logic [29:0] e;
    int x0, y0;
    map_kind = 0; bp = np; bl = nl; bs = ns; d0 = ndone;
    launch(10, 20, 3, 2, 1'b0, s);
    wait_done(d0);
    verify(10, 20, 3, 2, 1'b0, bp, bl, s, "R4 blend value");
    e = ent_fn(20*DW + 10); x0 = int'(e[29:19]); y0 = int'(e[18:8]);
    check(sa[bs]   == y0*SW + x0,       "R3 read 0", sa[bs],   y0*SW + x0);
    check(sa[bs+1] == y0*SW + x0 + 1,   "R3 read 1", sa[bs+1], y0*SW + x0 + 1);
    check(sa[bs+2] == (y0+1)*SW + x0,   "R3 read 2", sa[bs+2], (y0+1)*SW + x0);
    check(sa[bs+3] == (y0+1)*SW + x0+1, "R3 read 3", sa[bs+3], (y0+1)*SW + x0 + 1);
  endtask

  task automatic t_nearest();
    int s, bp, bl, d0;
    map_kind = 0; bp = np; bl = nl; d0 = ndone;
    launch(7, 3, 4, 2, 1'b1, s);
    wait_done(d0);
    verify(7, 3, 4, 2, 1'b1, bp, bl, s, "R6 nearest value");
  endtask

  task automatic t_edge_clamp();
    int s, bp, bl, bs, d0;
    map_kind = 1; bp = np; bl = nl; bs = ns; d0 = ndone;
    launch(0, 0, 2, 1, 1'b0, s);
    wait_done(d0);
    verify(0, 0, 2, 1, 1'b0, bp, bl, s, "R5 clamped blend");
    check(sa[bs+3] == (SH-1)*SW + SW-1, "R5 corner read", sa[bs+3], (SH-1)*SW + SW-1);
    bp = np; bl = nl; d0 = ndone;
    launch(0, 0, 2, 1, 1'b1, s);
    wait_done(d0);
    verify(0, 0, 2, 1, 1'b1, bp, bl, s, "R5 R6 clamped nearest");
  endtask

  task automatic t_empty();
    int s, bp, d0;
    bp = np; d0 = ndone;
    launch(5, 5, 0, 3, 1'b0, s);
    wait_done(d0);
    check(done_cyc == s + 1, "R9 done cycle", done_cyc, s + 1);
    check(np == bp, "R9 no pixels", np - bp, 0);
  endtask

  task automatic t_busy_start();
    int s, bp, bl, d0;
    map_kind = 0; bp = np; bl = nl; d0 = ndone;
    launch(3, 4, 2, 2, 1'b0, s);
    repeat (9) @(negedge clk);
    win_x = 11'd50; win_w = 11'd5; nn_sel = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(d0);
    verify(3, 4, 2, 2, 1'b0, bp, bl, s, "R10 first window kept");
    repeat (20) @(negedge clk);
    check(np - bp == 4 && !busy, "R10 no second run", np - bp, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_blend_basic();
    t_nearest();
    t_edge_clamp();
    t_empty();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P*100000);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule